// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global shift register holding the outcomes of the most recent `M` resolved branches. It also keeps a table in which every row holds `2^M` saturating counters, each `N` bits wide. The low bits of the branch address pick a row, and the global history picks one counter within that row. A counter in the upper half of its range gives a taken prediction. There is no tag, so two addresses that agree in their row bits share a row.

The fetch side presents an address on `pred_pc` and reads `pred_taken` in the same cycle. It also reads `pred_hist`, the history value used for that guess, and keeps it alongside the branch. When the branch resolves, the execute side pulses `upd_valid` with the address, the real outcome and that saved history. On that clock edge the single counter chosen by the saved history is moved one step toward the outcome, and the outcome enters the global history as its newest bit. With `M = 0` the block becomes a plain table of one counter per address.

Top module: `corr_predictor`

## Requirements
- R1: After reset the global history reads zero on `pred_hist` and every counter holds 2^(N-1)-1, the weakly not-taken value, so `pred_taken` is 0 for every address.
- R2: `pred_taken` is combinational. It is 1 exactly when the counter in row `pred_pc[log2(ROWS)-1:0]`, at the position given by the current global history, is at least 2^(N-1).
- R3: A valid update with `upd_taken` = 1 raises the selected counter by one, and a counter already at 2^N-1 stays at 2^N-1.
- R4: A valid update with `upd_taken` = 0 lowers the selected counter by one, and a counter already at 0 stays at 0.
- R5: A valid update changes only the one counter in row `upd_pc[log2(ROWS)-1:0]` at the position `upd_hist`. This is the history passed back with the update, not the current history. The other counters in that row and all other rows keep their values.
- R6: On the clock edge of a valid update, the global history becomes {old history[M-2:0], `upd_taken`}, with the newest outcome in bit 0. The change shows on the next prediction.
- R7: While `upd_valid` is 0, no counter and no history bit changes, whatever the other update inputs carry.
- R8: Addresses that differ only above the row bits share all their counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | max(M,1) | Current global history, to be returned with the update |
| upd_valid | input | 1 | Update strobe for one resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | max(M,1) | History value that was used when this branch was predicted |

## Verification
The hardest case to reach from the ports is reading one chosen counter. A prediction always uses the current global history, and every update that trains a counter also shifts that history. The bench therefore steers the history to a wanted value first, by sending M updates to a separate scratch address. It then probes the target address, so it can check both saturation limits and that the neighbouring counters of the same row were left alone. Random traffic is confined to a few rows and their aliases, and often returns a history that differs from the current one. This tests that writes follow the passed-back history and that rows are shared without a tag.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  // Next value of an n-bit saturating counter moved one step toward 'up'.
  function automatic int unsigned ctr_next(int unsigned v, bit up, int unsigned n);
    int unsigned top;
    top = (32'd1 << n) - 32'd1;
    if (up) return (v == top) ? v : v + 32'd1;
    else    return (v == 32'd0) ? v : v - 32'd1;
  endfunction

  // A counter in the upper half of its range votes taken.
  function automatic bit ctr_is_taken(int unsigned v, int unsigned n);
    return v >= (32'd1 << (n - 1));
  endfunction

  // Weakly not-taken start value.
  function automatic int unsigned ctr_init(int unsigned n);
    return (32'd1 << (n - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/cbp_history.sv
module cbp_history #(
  parameter int M  = 2,
  localparam int HW = (M > 0) ? M : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          shift_bit,
  output logic [HW-1:0] hist
);

  generate
    if (M > 0) begin : g_hist
      logic [HW-1:0] hist_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= HW'({hist_q, shift_bit});
      end
      assign hist = hist_q;
    end else begin : g_nohist
      logic unused_in;
      assign unused_in = shift_en ^ shift_bit;
      assign hist = '0;
    end
  endgenerate

endmodule

// File: rtl/cbp_table.sv
module cbp_table #(
  parameter int M    = 2,
  parameter int N    = 2,
  parameter int ROWS = 1024,
  parameter int PC_W = 32,
  localparam int HW   = (M > 0) ? M : 1,
  localparam int SETS = 1 << M,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  input  logic [HW-1:0]   rd_hist,
  output logic [N-1:0]    rd_ctr,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [HW-1:0]   wr_hist,
  input  logic            wr_taken,
  output logic [N-1:0]    wr_old,
  output logic [N-1:0]    wr_new
);

  logic [N-1:0]  ctr_q [ROWS][SETS];
  logic [RW-1:0] rd_row, wr_row;
  logic [HW-1:0] rd_set, wr_set;

  assign rd_row = rd_pc[RW-1:0];
  assign wr_row = wr_pc[RW-1:0];

  generate
    if (M > 0) begin : g_sel
      assign rd_set = rd_hist;
      assign wr_set = wr_hist;
    end else begin : g_nosel
      assign rd_set = '0;
      assign wr_set = '0;
    end
  endgenerate

  assign rd_ctr = ctr_q[rd_row][rd_set];
  assign wr_old = ctr_q[wr_row][wr_set];
  assign wr_new = N'(cbp_pkg::ctr_next(32'(wr_old), wr_taken, N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int s = 0; s < SETS; s++)
          ctr_q[r][s] <= N'(cbp_pkg::ctr_init(N));
    end else if (wr_en) begin
      ctr_q[wr_row][wr_set] <= wr_new;
    end
  end

endmodule

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int M    = 2,
  parameter int N    = 2,
  parameter int ROWS = 1024,
  parameter int PC_W = 32,
  localparam int HW  = (M > 0) ? M : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic [HW-1:0]   pred_hist,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [HW-1:0]   upd_hist
);

  // Named internal events, visible to the bound checker.
  logic [N-1:0] rd_ctr;
  logic [N-1:0] upd_old;
  logic [N-1:0] upd_new;

  cbp_history #(.M(M)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist      (pred_hist)
  );

  cbp_table #(.M(M), .N(N), .ROWS(ROWS), .PC_W(PC_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_pc    (pred_pc),
    .rd_hist  (pred_hist),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_pc    (upd_pc),
    .wr_hist  (upd_hist),
    .wr_taken (upd_taken),
    .wr_old   (upd_old),
    .wr_new   (upd_new)
  );

  assign pred_taken = cbp_pkg::ctr_is_taken(32'(rd_ctr), N);

endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
  parameter int M  = 2,
  parameter int N  = 2,
  localparam int HW = (M > 0) ? M : 1,
  localparam logic [N-1:0] TOP = {N{1'b1}}
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_valid,
  input logic          upd_taken,
  input logic [HW-1:0] pred_hist,
  input logic [N-1:0]  upd_old,
  input logic [N-1:0]  upd_new
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_old == TOP) |-> upd_new == TOP);

  assert_increment_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_old != TOP) |-> upd_new == upd_old + 1'b1);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_old == '0) |-> upd_new == '0);

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_old != '0) |-> upd_new == upd_old - 1'b1);

  assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist));

  generate
    if (M > 0) begin : g_shift_chk
      assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> pred_hist == HW'({$past(pred_hist), $past(upd_taken)}));
    end
  endgenerate

endmodule

bind corr_predictor cbp_checker #(.M(M), .N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_taken (upd_taken),
  .pred_hist (pred_hist),
  .upd_old   (upd_old),
  .upd_new   (upd_new)
);

// File: tb/tb_corr_predictor.sv
module tb_corr_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int M    = 2;
  localparam int N    = 2;
  localparam int ROWS = 1024;
  localparam int PC_W = 32;
  localparam int HW   = (M > 0) ? M : 1;
  localparam int SETS = 1 << M;
  localparam int unsigned SCRATCH = 900;
  localparam int unsigned TGT     = 37;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic [HW-1:0]   upd_hist = '0;
  logic            upd_valid = 0, upd_taken = 0;
  logic            pred_taken;
  logic [HW-1:0]   pred_hist;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int unsigned mdl [ROWS][SETS];
  int unsigned mdl_hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_predictor #(.M(M), .N(N), .ROWS(ROWS), .PC_W(PC_W)) dut (.*);

  function automatic int unsigned ref_step(int unsigned v, bit t);
    if (t) return (v >= (1 << N) - 1) ? (1 << N) - 1 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  function automatic bit ref_taken(int unsigned v);
    return 2 * v >= (1 << N);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic upd(int unsigned pc, bit t, int unsigned h);
    @(negedge clk);
    upd_pc = pc; upd_taken = t; upd_hist = HW'(h); upd_valid = 1;
    @(negedge clk);
    upd_valid = 0;
    mdl[pc % ROWS][h % SETS] = ref_step(mdl[pc % ROWS][h % SETS], t);
    mdl_hist = ((mdl_hist << 1) | 32'(t)) % SETS;
  endtask

  task automatic probe(int unsigned pc, string req);
    pred_pc = pc;
    #1;
    check(pred_taken == ref_taken(mdl[pc % ROWS][mdl_hist]), req,
          int'(pred_taken), int'(ref_taken(mdl[pc % ROWS][mdl_hist])));
    check(32'(pred_hist) == mdl_hist, {req, " history"}, int'(pred_hist), int'(mdl_hist));
  endtask

  task automatic probe_exp(int unsigned pc, bit exp, string req);
    pred_pc = pc;
    #1;
    check(pred_taken == exp, req, int'(pred_taken), int'(exp));
  endtask

  // Drive the global history to h through updates at the scratch address.
  task automatic steer(int unsigned h);
    for (int i = M - 1; i >= 0; i--) upd(SCRATCH, h[i], mdl_hist);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < ROWS; r++)
      for (int s = 0; s < SETS; s++) mdl[r][s] = (1 << (N - 1)) - 1;
    mdl_hist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    probe_exp(0, 0, "R1 reset predict");
    probe_exp(ROWS - 1, 0, "R1 reset predict");
    probe(TGT, "R1");

    // R2/R3: train TGT at history 2 once, read it back at history 2
    steer(2);
    upd(TGT, 1, mdl_hist);
    steer(2);
    probe_exp(TGT, 1, "R2 trained counter predicts taken");
    // R5: same row, other history position untouched
    steer(1);
    probe_exp(TGT, 0, "R5 neighbour counter unchanged");

    // R3 saturation, using passed-back history 2 regardless of current
    repeat (4) upd(TGT, 1, 2);
    upd(TGT, 0, 2);
    steer(2);
    probe_exp(TGT, 1, "R3 saturated counter stays high after one decrement");
    // R4 saturation at zero
    repeat (5) upd(TGT, 0, 2);
    upd(TGT, 1, 2);
    steer(2);
    probe_exp(TGT, 0, "R4 floor then one increment still not taken");
    probe(TGT, "R4");

    // R8: aliasing address trains TGT row at history 0
    repeat (2) upd(TGT + ROWS, 1, 0);
    steer(0);
    probe_exp(TGT, 1, "R8 alias shares counter");
    probe(TGT + 3 * ROWS, "R8");

    // R7: update fields move with strobe low
    steer(3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      upd_pc = TGT; upd_taken = 1; upd_hist = HW'(3);
    end
    @(negedge clk);
    probe(TGT, "R7 ignored without strobe");
    probe_exp(TGT, 0, "R7 counter at history 3 still weak");

    // R6: history shift order
    upd(SCRATCH, 1, 0);
    upd(SCRATCH, 0, 0);
    check(pred_hist == HW'(2), "R6 newest outcome in bit 0", int'(pred_hist), 2);

    // Random traffic over few rows plus aliases (R2 R5 R6 R8)
    for (int i = 0; i < 3000; i++) begin
      int unsigned pc, h;
      bit t;
      pc = ($urandom % 8) + ($urandom % 4) * ROWS;
      t  = (($urandom % 8) < (pc % 8)) ? 1'b1 : 1'b0;
      h  = ($urandom % 2) ? mdl_hist : $urandom % SETS;
      upd(pc, t, h);
      probe(($urandom % 8) + ($urandom % 4) * ROWS, "R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule